// File: doc/BRIEF.md
# Accumulator and Link Operate Unit

This unit executes the register-only operate instructions of a 12-bit accumulator machine. It holds the accumulator and the one-bit link, and on an execute strobe it decodes a 12-bit instruction word. The word is a bit mask of micro-operations: clear, complement, increment and rotate through the link. Every selected micro-operation is applied in a fixed order within a single instruction, and the result is written back on the same clock edge.

Because the operations are merged in one word, one instruction can build small constants. An example is clear both registers, set the link, increment, then rotate. A compatibility input selects the rules of an older machine. Under those rules a rotate may not appear in the same word as an increment or an accumulator complement. Such a word is refused: it changes no state and raises a one-cycle flag.

Top module: `opr_micro_unit`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the accumulator reads 0, the link reads 0 and `illegal_o` reads 0.
- R2: The state changes only on an edge where `exec_i` is high and the word is an operate word of this group. Such a word has bits [11:9] = 3'b111 and bit [8] = 0. Any other word, or a word with `exec_i` low, leaves the accumulator and the link unchanged.
- R3: Bit [7] clears the accumulator and bit [6] clears the link. Both clears act before every other micro-operation.
- R4: Bit [5] complements the accumulator and bit [4] complements the link. Both complements act after the clears, so a clear combined with a complement sets all ones.
- R5: Bit [0] adds one to the 13-bit value {link, accumulator} after the complements. A carry out of the accumulator therefore toggles the link.
- R6: Bit [2] rotates {link, accumulator} left by one place and bit [3] rotates it right by one place. The rotate acts last, and the link takes part in the rotation.
- R7: Bit [1] together with a rotate bit makes the rotation two places instead of one. Bit [1] with no rotate bit has no effect.
- R8: A word with both bit [2] and bit [3] set performs no rotation. All other micro-operations in that word still apply.
- R9: While `legacy_i` is high, a word that rotates (exactly one of bits [2] and [3] set) and also has bit [0] or bit [5] set leaves the state unchanged. The same edge sets `illegal_o` high.
- R10: With `legacy_i` low, clear, complement and increment may be combined with a rotate in one word. For example, octal 7325 yields accumulator 3, and octal 7327 yields accumulator 6 with link 0.
- R11: `illegal_o` stays high for exactly one cycle per refused word. It is never set for an accepted word, or for any word while `legacy_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe for the current word |
| legacy_i | input | 1 | Enables the older combination rule |
| instr_i | input | 12 | Instruction word |
| ac_o | output | DATA_W | Accumulator |
| link_o | output | 1 | Link bit |
| illegal_o | output | 1 | One-cycle flag for a refused word |

## Verification
The bench builds the unit at its default 12-bit accumulator width. This makes the octal constant-building words, the carry out of an all-ones accumulator into the link, and two-place rotations across the link boundary directly comparable with hand-computed values. The bench drives a chained sequence of words, so each result depends on the state left by the previous word. It then switches the compatibility mode on and off within that sequence, to show which combinations are refused and which are accepted.

// File: rtl/opr_pkg.sv
package opr_pkg;

    localparam int INSN_W  = 12;
    localparam int OPC_HI  = 11;
    localparam int OPC_LO  = 9;
    localparam int GRP_BIT = 8;
    localparam int B_CLA   = 7;
    localparam int B_CLL   = 6;
    localparam int B_CMA   = 5;
    localparam int B_CML   = 4;
    localparam int B_RAR   = 3;
    localparam int B_RAL   = 2;
    localparam int B_DBL   = 1;
    localparam int B_IAC   = 0;
    localparam logic [OPC_HI-OPC_LO:0] OPC_OPERATE = '1;

    typedef enum logic [1:0] {
        ROT_NONE  = 2'd0,
        ROT_LEFT  = 2'd1,
        ROT_RIGHT = 2'd2
    } rot_dir_e;

    typedef struct packed {
        logic     grp1;
        logic     clr_ac;
        logic     clr_lk;
        logic     cmp_ac;
        logic     cmp_lk;
        logic     inc;
        rot_dir_e dir;
        logic     dbl;
    } opr_ctl_t;

    // Both direction bits together cancel the rotation.
    function automatic rot_dir_e pick_dir(input logic left, input logic right);
        if (left && !right)
            return ROT_LEFT;
        else if (right && !left)
            return ROT_RIGHT;
        else
            return ROT_NONE;
    endfunction

endpackage

// File: rtl/opr_decode.sv
module opr_decode
    import opr_pkg::*;
(
    input  logic [INSN_W-1:0] instr_i,
    input  logic              legacy_i,
    output opr_ctl_t          ctl_o,
    output logic              bad_combo_o
);

    always_comb begin
        ctl_o.grp1   = (instr_i[OPC_HI:OPC_LO] == OPC_OPERATE) && !instr_i[GRP_BIT];
        ctl_o.clr_ac = instr_i[B_CLA];
        ctl_o.clr_lk = instr_i[B_CLL];
        ctl_o.cmp_ac = instr_i[B_CMA];
        ctl_o.cmp_lk = instr_i[B_CML];
        ctl_o.inc    = instr_i[B_IAC];
        ctl_o.dir    = pick_dir(instr_i[B_RAL], instr_i[B_RAR]);
        ctl_o.dbl    = instr_i[B_DBL];
    end

    // Older rule: a rotation may not share a word with increment or AC complement.
    assign bad_combo_o = legacy_i && (ctl_o.dir != ROT_NONE) && (ctl_o.inc || ctl_o.cmp_ac);

endmodule

// File: rtl/opr_rotator.sv
module opr_rotator
    import opr_pkg::*;
#(
    parameter int RING_W = 13
) (
    input  logic [RING_W-1:0] ring_i,
    input  rot_dir_e          dir_i,
    input  logic              dbl_i,
    output logic [RING_W-1:0] ring_o
);

    localparam int N_STEPS = 2;

    logic [RING_W-1:0] lft [N_STEPS];
    logic [RING_W-1:0] rgt [N_STEPS];

    for (genvar g = 0; g < N_STEPS; g++) begin : g_step
        localparam int SH = g + 1;
        assign lft[g] = {ring_i[RING_W-1-SH:0], ring_i[RING_W-1:RING_W-SH]};
        assign rgt[g] = {ring_i[SH-1:0], ring_i[RING_W-1:SH]};
    end

    always_comb begin
        unique case (dir_i)
            ROT_LEFT:  ring_o = dbl_i ? lft[1] : lft[0];
            ROT_RIGHT: ring_o = dbl_i ? rgt[1] : rgt[0];
            default:   ring_o = ring_i;
        endcase
    end

endmodule

// File: rtl/opr_datapath.sv
module opr_datapath
    import opr_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] ac_i,
    input  logic              lk_i,
    input  opr_ctl_t          ctl_i,
    output logic [DATA_W-1:0] ac_o,
    output logic              lk_o
);

    localparam int RING_W = DATA_W + 1;

    logic [RING_W-1:0] after_clr;
    logic [RING_W-1:0] after_cmp;
    logic [RING_W-1:0] after_inc;
    logic [RING_W-1:0] after_rot;

    always_comb begin
        after_clr = {lk_i, ac_i};
        if (ctl_i.clr_ac) after_clr[DATA_W-1:0] = '0;
        if (ctl_i.clr_lk) after_clr[DATA_W]     = 1'b0;

        after_cmp = after_clr;
        if (ctl_i.cmp_ac) after_cmp[DATA_W-1:0] = ~after_clr[DATA_W-1:0];
        if (ctl_i.cmp_lk) after_cmp[DATA_W]     = ~after_clr[DATA_W];

        after_inc = ctl_i.inc ? after_cmp + RING_W'(1) : after_cmp;
    end

    opr_rotator #(
        .RING_W (RING_W)
    ) rot_i (
        .ring_i (after_inc),
        .dir_i  (ctl_i.dir),
        .dbl_i  (ctl_i.dbl),
        .ring_o (after_rot)
    );

    assign ac_o = after_rot[DATA_W-1:0];
    assign lk_o = after_rot[DATA_W];

endmodule

// File: rtl/opr_micro_unit.sv
module opr_micro_unit
    import opr_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_i,
    input  logic              legacy_i,
    input  logic [INSN_W-1:0] instr_i,
    output logic [DATA_W-1:0] ac_o,
    output logic              link_o,
    output logic              illegal_o
);

    opr_ctl_t          ctl;
    logic              bad_combo;
    logic [DATA_W-1:0] ac_q, ac_nx;
    logic              lk_q, lk_nx;
    logic              ill_q;
    logic              accept;

    opr_decode dec_i (
        .instr_i     (instr_i),
        .legacy_i    (legacy_i),
        .ctl_o       (ctl),
        .bad_combo_o (bad_combo)
    );

    opr_datapath #(
        .DATA_W (DATA_W)
    ) dp_i (
        .ac_i  (ac_q),
        .lk_i  (lk_q),
        .ctl_i (ctl),
        .ac_o  (ac_nx),
        .lk_o  (lk_nx)
    );

    assign accept = exec_i && ctl.grp1 && !bad_combo;

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q  <= '0;
            lk_q  <= 1'b0;
            ill_q <= 1'b0;
        end else begin
            if (accept) begin
                ac_q <= ac_nx;
                lk_q <= lk_nx;
            end
            ill_q <= exec_i && ctl.grp1 && bad_combo;
        end
    end

    assign ac_o      = ac_q;
    assign link_o    = lk_q;
    assign illegal_o = ill_q;

endmodule

// File: rtl/opr_micro_unit_chk.sv
module opr_micro_unit_chk
    import opr_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              exec_i,
    input logic              legacy_i,
    input logic [INSN_W-1:0] instr_i,
    input logic [DATA_W-1:0] ac_o,
    input logic              link_o,
    input logic              illegal_o
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (ac_o == '0) && !link_o && !illegal_o);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !exec_i |=> $stable(ac_o) && $stable(link_o));

    p_other_group_r2: assert property (@(posedge clk) disable iff (rst)
        (exec_i && (instr_i[OPC_HI:OPC_LO] != OPC_OPERATE)) |=> $stable(ac_o) && $stable(link_o));

    p_refused_hold_r9: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $stable(ac_o) && $stable(link_o));

    p_flag_cause_r11: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $past(legacy_i) && $past(exec_i));

    p_flag_single_r11: assert property (@(posedge clk) disable iff (rst)
        (illegal_o && !exec_i) |=> !illegal_o);

endmodule

bind opr_micro_unit opr_micro_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .exec_i    (exec_i),
    .legacy_i  (legacy_i),
    .instr_i   (instr_i),
    .ac_o      (ac_o),
    .link_o    (link_o),
    .illegal_o (illegal_o)
);

// File: tb/opr_micro_unit_tb_top.sv
`timescale 1ns/1ps
module opr_micro_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_i = 1'b0;
    logic        legacy_i = 1'b0;
    logic [11:0] instr_i = '0;
    logic [11:0] ac_o;
    logic        link_o;
    logic        illegal_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    opr_micro_unit #(.DATA_W(12)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .exec_i    (exec_i),
        .legacy_i  (legacy_i),
        .instr_i   (instr_i),
        .ac_o      (ac_o),
        .link_o    (link_o),
        .illegal_o (illegal_o)
    );

    // {legacy, word, expected AC, expected link, expected flag, requirement}
    localparam int NV = 20;
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 12'o7300, 12'o0000, 1'b0, 1'b0, 8'd3},  // R3 clear both
        {1'b0, 12'o7040, 12'o7777, 1'b0, 1'b0, 8'd4},  // R4 complement AC
        {1'b0, 12'o7001, 12'o0000, 1'b1, 1'b0, 8'd5},  // R5 carry into link
        {1'b0, 12'o7010, 12'o4000, 1'b0, 1'b0, 8'd6},  // R6 right one
        {1'b0, 12'o7004, 12'o0000, 1'b1, 1'b0, 8'd6},  // R6 left one
        {1'b0, 12'o7020, 12'o0000, 1'b0, 1'b0, 8'd4},  // R4 complement link
        {1'b0, 12'o7325, 12'o0003, 1'b0, 1'b0, 8'd10}, // R10 constant 3
        {1'b0, 12'o7327, 12'o0006, 1'b0, 1'b0, 8'd10}, // R10 constant 6
        {1'b0, 12'o7012, 12'o0001, 1'b1, 1'b0, 8'd7},  // R7 right two
        {1'b0, 12'o7006, 12'o0006, 1'b0, 1'b0, 8'd7},  // R7 left two
        {1'b0, 12'o7054, 12'o7771, 1'b0, 1'b0, 8'd8},  // R8 both directions
        {1'b0, 12'o6000, 12'o7771, 1'b0, 1'b0, 8'd2},  // R2 other opcode
        {1'b0, 12'o7400, 12'o7771, 1'b0, 1'b0, 8'd2},  // R2 other group
        {1'b0, 12'o7200, 12'o0000, 1'b0, 1'b0, 8'd3},  // R3 clear AC
        {1'b0, 12'o7120, 12'o0000, 1'b1, 1'b0, 8'd4},  // R4 clear then complement link
        {1'b0, 12'o7240, 12'o7777, 1'b1, 1'b0, 8'd4},  // R4 clear then complement AC
        {1'b1, 12'o7041, 12'o0001, 1'b1, 1'b0, 8'd11}, // R11 legal in legacy
        {1'b1, 12'o7004, 12'o0003, 1'b0, 1'b0, 8'd11}, // R11 lone rotate legal
        {1'b1, 12'o7005, 12'o0003, 1'b0, 1'b1, 8'd9},  // R9 rotate with increment
        {1'b1, 12'o7050, 12'o0003, 1'b0, 1'b1, 8'd9}   // R9 rotate with complement
    };

    task automatic check(input int req, input logic [11:0] ac_e,
                         input logic l_e, input logic ill_e);
        total++;
        if (ac_o !== ac_e || link_o !== l_e || illegal_o !== ill_e) begin
            bad++;
            $display("FAIL R%0d: ac=%o link=%b ill=%b expected ac=%o link=%b ill=%b",
                     req, ac_o, link_o, illegal_o, ac_e, l_e, ill_e);
        end
    endtask

    task automatic apply(input logic leg, input logic [11:0] w, input logic ex);
        @(negedge clk);
        legacy_i = leg;
        instr_i  = w;
        exec_i   = ex;
        @(negedge clk);
        exec_i   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 12'o0000, 1'b0, 1'b0);      // R1 during reset
        rst = 1'b0;
        @(negedge clk);
        check(1, 12'o0000, 1'b0, 1'b0);      // R1 after release

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][34], VEC[i][33:22], 1'b1);
            check(int'(VEC[i][7:0]), VEC[i][21:10], VEC[i][9], VEC[i][8]);
        end

        @(negedge clk);
        check(11, 12'o0003, 1'b0, 1'b0);     // R11 flag dropped

        apply(1'b0, 12'o7040, 1'b0);
        check(2, 12'o0003, 1'b0, 1'b0);      // R2 strobe low

        apply(1'b0, 12'o7005, 1'b1);
        check(10, 12'o0010, 1'b0, 1'b0);     // R10 combination accepted, no flag

        apply(1'b0, 12'o7002, 1'b1);
        check(7, 12'o0010, 1'b0, 1'b0);      // R7 double bit alone

        apply(1'b0, 12'o7240, 1'b1);
        apply(1'b0, 12'o7020, 1'b1);
        check(4, 12'o7777, 1'b1, 1'b0);      // R4 all ones with link set
        apply(1'b0, 12'o7001, 1'b1);
        check(5, 12'o0000, 1'b0, 1'b0);      // R5 full wrap

        apply(1'b0, 12'o7325, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(1, 12'o0000, 1'b0, 1'b0);      // R1 reset mid run

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: ran=%0d expected finish", 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule